// File: doc/BRIEF.md
# Interrupt Status Mask Pending Controller

This block manages the single interrupt line of one peripheral function. The raw line, which may change at any time, is brought into the local clock domain through a chain of flops and shown as a read-only status bit. While the mask bit is clear, a high status sets a sticky pending bit. Software clears that bit by writing a one to it. When hardware sets the bit and software clears it in the same cycle, the hardware set takes effect.

An enable bit decides whether the pending state produces any outgoing traffic. The first configuration input selects message-signalled interrupts, and the second one turns legacy messages off. A message-signalled request or a legacy assert strobe is raised when the pending bit rises. The same strobe is raised again after any software write that leaves the pending bit set. A legacy deassert strobe is raised only when a software write clears the pending bit. Every output is a single-cycle strobe. Building the bus messages from these strobes is left to the surrounding logic.

Top module: `irq_pend_ctrl`

## Requirements
- R1: The register read value has enable at bit 24, pending at bit 16, mask at bit 8 and status at bit 0. Every other bit reads as zero, even after a write of all ones.
- R2: After reset the register reads 0x0000_0100 (mask set, everything else clear) and no strobe is active.
- R3: The status bit shows the interrupt input after two clock edges of synchronization. It reads 1 in the cycle that follows the second edge after the input rises.
- R4: The pending bit is set on the edge after a cycle in which status is 1 and mask is 0. While mask is 1, status never sets it.
- R5: A write with bit 16 = 1 clears pending, and a write with bit 16 = 0 leaves it unchanged. If status is 1 and mask is 0 in the write cycle, pending stays 1.
- R6: With enable = 1 and the message-signalled enable input high, the MSI request strobe is raised in the cycle where pending first reads 1. It is raised again in the cycle after any write that leaves pending at 1.
- R7: With enable = 1 and the legacy-off input low, the assert strobe follows the same rule as R6. The deassert strobe is raised in the cycle after a write that clears pending, and assert and deassert are never high together.
- R8: When the enable value in effect after a write is 0, no MSI, assert or deassert strobe is raised. This holds whatever the configuration inputs are and whatever happens to the pending bit.
- R9: Each strobe lasts one cycle. An input held high produces exactly one message for each rise of pending, with no repeats while the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw_i | input | 1 | Raw interrupt line from the peripheral, asynchronous |
| msi_en_i | input | 1 | Message-signalled interrupts enabled |
| legacy_off_i | input | 1 | Legacy assert/deassert messages disabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| msi_req_o | output | 1 | MSI request strobe |
| int_assert_o | output | 1 | Legacy assert message strobe |
| int_deassert_o | output | 1 | Legacy deassert message strobe |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a hardware set. The bench creates it by holding the interrupt line high with the mask open, so that the set condition is present on every edge. It then issues a write-one-to-clear and checks three things: pending stays set, a re-send strobe appears, and no deassert strobe appears. A second hard case is the re-send that a write alone causes. The bench reaches it by setting pending while the enable bit is 0, dropping the line, and only then writing the enable bit to 1.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int REG_W    = 32;
  localparam int EN_BIT   = 24;
  localparam int PEND_BIT = 16;
  localparam int MASK_BIT = 8;
  localparam int STAT_BIT = 0;

  typedef struct packed {
    logic en;
    logic pend;
    logic mask;
    logic stat;
  } ctl_state_t;

  typedef struct packed {
    logic rise;   // pending goes 0 -> 1
    logic keep;   // write leaves pending set
    logic clr;    // write clears pending
  } pend_evt_t;

  function automatic logic [REG_W-1:0] pack_reg(ctl_state_t s);
    logic [REG_W-1:0] r;
    r           = '0;
    r[EN_BIT]   = s.en;
    r[PEND_BIT] = s.pend;
    r[MASK_BIT] = s.mask;
    r[STAT_BIT] = s.stat;
    return r;
  endfunction

  // hardware set dominates the software clear
  function automatic logic next_pend(logic cur, logic hw_set, logic sw_clr);
    return hw_set | (cur & ~sw_clr);
  endfunction

  function automatic pend_evt_t classify(logic wr, logic w1c, logic cur, logic nxt);
    pend_evt_t e;
    e.rise = ~cur & nxt;
    e.keep = wr & cur & nxt;
    e.clr  = wr & w1c & cur & ~nxt;
    return e;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[N-2:0], d_i};
  end

  assign q_o = sr_q[N-1];
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             en_q_o,
  output logic             mask_q_o,
  output logic             pend_q_o,
  output logic             en_nx_o,
  output logic             hw_set_o,
  output pend_evt_t        evt_o
);
  logic en_q, mask_q, pend_q;
  logic en_nx, mask_nx, pend_nx;
  logic sw_clr, hw_set;

  assign hw_set  = status_i & ~mask_q;
  assign sw_clr  = wr_en_i & wr_data_i[PEND_BIT];
  assign pend_nx = next_pend(pend_q, hw_set, sw_clr);
  assign en_nx   = wr_en_i ? wr_data_i[EN_BIT]   : en_q;
  assign mask_nx = wr_en_i ? wr_data_i[MASK_BIT] : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_nx;
      mask_q <= mask_nx;
      pend_q <= pend_nx;
    end
  end

  assign evt_o    = classify(wr_en_i, wr_data_i[PEND_BIT], pend_q, pend_nx);
  assign en_q_o   = en_q;
  assign mask_q_o = mask_q;
  assign pend_q_o = pend_q;
  assign en_nx_o  = en_nx;
  assign hw_set_o = hw_set;
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
  import irq_pend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      msi_en_i,
  input  logic      legacy_off_i,
  input  pend_evt_t evt_i,
  output logic      msi_o,
  output logic      asrt_o,
  output logic      deasrt_o
);
  logic fire, legacy_ok;
  logic msi_q, asrt_q, deasrt_q;

  assign fire      = evt_i.rise | evt_i.keep;
  assign legacy_ok = en_i & ~legacy_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_q    <= 1'b0;
      asrt_q   <= 1'b0;
      deasrt_q <= 1'b0;
    end else begin
      msi_q    <= en_i & msi_en_i & fire;
      asrt_q   <= legacy_ok & fire;
      deasrt_q <= legacy_ok & evt_i.clr;
    end
  end

  assign msi_o    = msi_q;
  assign asrt_o   = asrt_q;
  assign deasrt_o = deasrt_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_raw_i,
  input  logic        msi_en_i,
  input  logic        legacy_off_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        msi_req_o,
  output logic        int_assert_o,
  output logic        int_deassert_o
);
  logic       status;
  logic       en_q, mask_q, pend_q, en_nx;
  logic       pend_hw_set;
  pend_evt_t  pend_evt;
  ctl_state_t st;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_raw_i), .q_o(status)
  );

  irq_pend_reg u_reg (
    .clk(clk), .rst_n(rst_n), .status_i(status),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .en_q_o(en_q), .mask_q_o(mask_q), .pend_q_o(pend_q),
    .en_nx_o(en_nx), .hw_set_o(pend_hw_set), .evt_o(pend_evt)
  );

  irq_msg_gen u_msg (
    .clk(clk), .rst_n(rst_n), .en_i(en_nx),
    .msi_en_i(msi_en_i), .legacy_off_i(legacy_off_i), .evt_i(pend_evt),
    .msi_o(msi_req_o), .asrt_o(int_assert_o), .deasrt_o(int_deassert_o)
  );

  assign st.en   = en_q;
  assign st.pend = pend_q;
  assign st.mask = mask_q;
  assign st.stat = status;
  assign rd_data_o = pack_reg(st);
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msi_en_i,
  input logic [31:0] rd_data_o,
  input logic        msi_req_o,
  input logic        int_assert_o,
  input logic        int_deassert_o,
  input logic        pend_hw_set
);
  // R5: a set condition always leaves pending high
  a_r5_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_hw_set |=> rd_data_o[16]);

  // R4: pending only rises after status with open mask
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data_o[16]) |-> $past(rd_data_o[0] && !rd_data_o[8]));

  // R6: MSI only while pending is visible
  a_r6_msi_pend: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |-> rd_data_o[16]);

  // R6: a rising pending with enable and MSI on yields a request
  a_r6_rise_msi: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_data_o[16]) && rd_data_o[24] && $past(msi_en_i)) |-> msi_req_o);

  // R7: deassert only after pending is cleared, never with assert
  a_r7_deassert_clear: assert property (@(posedge clk) disable iff (!rst_n)
    int_deassert_o |-> (!rd_data_o[16] && !int_assert_o));

  // R8: no strobe without enable
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_req_o || int_assert_o || int_deassert_o) |-> rd_data_o[24]);

  // R1: reserved bits stay zero
  a_r1_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & 32'hFEFE_FEFE) == 32'h0);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en_i(msi_en_i), .rd_data_o(rd_data_o),
  .msi_req_o(msi_req_o), .int_assert_o(int_assert_o),
  .int_deassert_o(int_deassert_o), .pend_hw_set(pend_hw_set)
);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_raw_i = 1'b0;
  logic        msi_en_i = 1'b1;
  logic        legacy_off_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        msi_req_o, int_assert_o, int_deassert_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_pend_ctrl u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] strobes();
    return {msi_req_o, int_assert_o, int_deassert_o};
  endfunction

  task automatic do_write(logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 reset value", rd_data_o, 32'h0000_0100);
    check("R2 reset strobes", {29'd0, strobes()}, 32'd0);
  endtask

  task automatic t_masked();
    @(negedge clk); irq_raw_i = 1'b1;
    idle(1);
    check("R3 status not yet", rd_data_o, 32'h0000_0100);
    idle(1);
    check("R3 status after sync", rd_data_o, 32'h0000_0101);
    idle(3);
    check("R4 masked no pending", rd_data_o, 32'h0000_0101);
    check("R4 masked no strobe", {29'd0, strobes()}, 32'd0);
  endtask

  task automatic t_unmask();
    do_write(32'h0100_0000);
    check("R4 unmask write", rd_data_o, 32'h0100_0001);
    check("R9 no early strobe", {29'd0, strobes()}, 32'd0);
    idle(1);
    check("R4 pending set", rd_data_o, 32'h0101_0001);
    check("R6 R7 rise strobes", {29'd0, strobes()}, 32'b110);
    idle(1);
    check("R9 single cycle", {29'd0, strobes()}, 32'd0);
    idle(3);
    check("R9 no repeat while high", {29'd0, strobes()}, 32'd0);
  endtask

  task automatic t_hw_wins();
    do_write(32'h0101_0000);
    check("R5 hw wins pending", rd_data_o, 32'h0101_0001);
    check("R5 R6 keep strobe no deassert", {29'd0, strobes()}, 32'b110);
  endtask

  task automatic t_resend_and_clear();
    @(negedge clk); irq_raw_i = 1'b0;
    idle(4);
    check("R5 pending holds after line drop", rd_data_o, 32'h0101_0000);
    check("R9 quiet", {29'd0, strobes()}, 32'd0);
    do_write(32'h0100_0000);
    check("R5 write zero no effect", rd_data_o, 32'h0101_0000);
    check("R6 R7 resend after write", {29'd0, strobes()}, 32'b110);
    do_write(32'h0101_0000);
    check("R5 w1c clears", rd_data_o, 32'h0100_0000);
    check("R7 deassert on clear", {29'd0, strobes()}, 32'b001);
    idle(1);
    check("R9 deassert single", {29'd0, strobes()}, 32'd0);
  endtask

  task automatic t_legacy_off();
    legacy_off_i = 1'b1;
    @(negedge clk); irq_raw_i = 1'b1;
    idle(3);
    check("R7 legacy off msi only", {29'd0, strobes()}, 32'b100);
    @(negedge clk); irq_raw_i = 1'b0;
    idle(3);
    do_write(32'h0101_0000);
    check("R7 legacy off no deassert", {29'd0, strobes()}, 32'd0);
    check("R5 cleared", rd_data_o, 32'h0100_0000);
    legacy_off_i = 1'b0;
  endtask

  task automatic t_msi_off();
    msi_en_i = 1'b0;
    @(negedge clk); irq_raw_i = 1'b1;
    idle(3);
    check("R6 msi off assert only", {29'd0, strobes()}, 32'b010);
    @(negedge clk); irq_raw_i = 1'b0;
    idle(3);
    do_write(32'h0101_0000);
    check("R7 deassert with msi off", {29'd0, strobes()}, 32'b001);
    msi_en_i = 1'b1;
  endtask

  task automatic t_disabled();
    do_write(32'h0000_0000);
    @(negedge clk); irq_raw_i = 1'b1;
    idle(3);
    check("R8 pending while disabled", rd_data_o, 32'h0001_0001);
    check("R8 no strobe on rise", {29'd0, strobes()}, 32'd0);
    @(negedge clk); irq_raw_i = 1'b0;
    idle(3);
    do_write(32'h0001_0000);
    check("R8 clear no deassert", {29'd0, strobes()}, 32'd0);
    check("R8 cleared", rd_data_o, 32'h0000_0000);
    @(negedge clk); irq_raw_i = 1'b1;
    idle(3);
    @(negedge clk); irq_raw_i = 1'b0;
    idle(3);
    do_write(32'h0100_0000);
    check("R6 enable write resends", {29'd0, strobes()}, 32'b110);
    do_write(32'hFFFF_FFFF);
    check("R1 reserved read zero", rd_data_o, 32'h0100_0100);
    check("R7 deassert from all ones", {29'd0, strobes()}, 32'b001);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_masked();
    t_unmask();
    t_hw_wins();
    t_resend_and_clear();
    t_legacy_off();
    t_msi_off();
    t_disabled();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule